// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block produces the 1 ms frame rhythm a full-speed USB host controller needs. A remaining-time counter is loaded from a programmable frame interval and decremented on each 12 MHz bit-time tick enable. When the counter is at zero on a tick, a frame boundary occurs. The counter then reloads, and the 16-bit frame number advances and is published. One cycle later the block emits the start-of-frame event, the request for the start-of-frame token, and any frame-number-overflow or scheduling-overrun events. A separate one-cycle strobe marks the frame number update and stands in for the memory writeback of that number.

A 32-bit configuration word holds the interval in its low half and the largest-packet budget in its upper half. The budget is the number of bit times a maximum-size transaction needs. The `transaction_fits` output tells the scheduler whether the time left in the frame still covers that budget. A new configuration word is held as pending and is only applied at the next frame boundary. A `run` input gates the whole timer.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame number is 0, the remaining count and the active interval are 11999, the active budget is 10104 (that is, (6*(11999-210))/7 with integer division), the overrun count is 0 and no event strobe is high.
- R2: While `run` is high and `remaining` is nonzero, each cycle with `tick` high lowers `remaining` by exactly one. Cycles without `tick` leave it unchanged.
- R3: A cycle with `run`, `tick` and `remaining == 0` is a frame boundary. On the next cycle `remaining` equals the pending interval (bits 15:0 of the configuration), the frame number has risen by one modulo 65536, and `fn_updated` is high for that single cycle.
- R4: `sof_event` and `sof_token_req` are high exactly in the cycle after each `fn_updated` cycle, so start of frame always follows the frame number update.
- R5: `fn_overflow_event` is high together with `sof_event` whenever the update changed bit 15 of the frame number, in either direction (0 to 1 at 32768, 1 to 0 at the wrap to 0).
- R6: If `sched_busy` is high in the boundary cycle, `overrun_event` is high together with the following `sof_event`, and the 2-bit `overrun_count` rises by one modulo 4 in that same cycle.
- R7: A write with `cfg_we` only updates the pending word. `interval_active`, `budget_active` (bits 31:16) and the reload value take it over at the next boundary. A write made in the boundary cycle itself applies at the boundary after that.
- R8: `transaction_fits` is high exactly when `remaining >= budget_active`.
- R9: While `run` is low, no boundary occurs. The frame number and `remaining` hold, and no new events are started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable |
| tick | input | 1 | 12 MHz bit-time enable |
| sched_busy | input | 1 | Schedule still running for the current frame |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration: budget in 31:16, interval in 15:0 |
| remaining | output | 16 | Bit times left in the current frame |
| frame_num | output | 16 | Current frame number |
| fn_updated | output | 1 | Frame number has just been updated |
| sof_event | output | 1 | Start-of-frame event strobe |
| sof_token_req | output | 1 | Request to send the start-of-frame token |
| fn_overflow_event | output | 1 | Frame number bit 15 changed |
| overrun_event | output | 1 | Schedule overran the frame |
| overrun_count | output | 2 | Wrapping count of overruns |
| interval_active | output | 16 | Interval used by the running frame |
| budget_active | output | 16 | Largest-packet budget in force |
| transaction_fits | output | 1 | Remaining time covers the budget |

## Verification
The hardest case to reach is the frame-number overflow event. It needs bit 15 to change, which takes 32768 frames. At the default 12000 ticks per frame that would be far too many cycles. The bench therefore programs an interval of 0, so that every tick is a boundary. It then runs more than 65536 back-to-back frames, which drives bit 15 both up and back down through the wrap. A random phase with gapped ticks, toggling `run`, busy schedules and configuration writes that land in and around boundary cycles covers the deferred-write ordering and the wrap of the overrun count.

// File: rtl/ft_pkg.sv
package ft_pkg;

  // Bit times a maximum-size packet takes, derived from a frame interval.
  function automatic int unsigned budget_of(input int unsigned ivl);
    if (ivl < 210) return 0;
    return (6 * (ivl - 210)) / 7;
  endfunction

  // True when the top bit differs between two frame numbers.
  function automatic logic msb_flip(input logic old_msb, input logic new_msb);
    return old_msb ^ new_msb;
  endfunction

endpackage

// File: rtl/ft_countdown.sv
module ft_countdown #(
  parameter int unsigned W       = 16,
  parameter int unsigned INIT_VAL = 11999
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] remaining,
  output logic         boundary
);
  logic [W-1:0] cnt_q;

  assign boundary  = run && tick && (cnt_q == '0);
  assign remaining = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= W'(INIT_VAL);
    else if (boundary)        cnt_q <= reload_val;
    else if (run && tick)     cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ft_frame_number.sv
module ft_frame_number #(
  parameter int unsigned FN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            sched_busy,
  output logic [FN_W-1:0] frame_num,
  output logic            fn_updated,
  output logic            msb_toggled,
  output logic            busy_seen
);
  import ft_pkg::*;

  logic [FN_W-1:0] fn_q;
  logic [FN_W-1:0] fn_next;

  assign fn_next   = fn_q + 1'b1;
  assign frame_num = fn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q        <= '0;
      fn_updated  <= 1'b0;
      msb_toggled <= 1'b0;
      busy_seen   <= 1'b0;
    end else if (boundary) begin
      fn_q        <= fn_next;
      fn_updated  <= 1'b1;
      msb_toggled <= msb_flip(fn_q[FN_W-1], fn_next[FN_W-1]);
      busy_seen   <= sched_busy;
    end else begin
      fn_updated  <= 1'b0;
      msb_toggled <= 1'b0;
      busy_seen   <= 1'b0;
    end
  end
endmodule

// File: rtl/ft_event_stage.sv
module ft_event_stage #(
  parameter int unsigned OVR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fn_updated,
  input  logic             msb_toggled,
  input  logic             busy_seen,
  output logic             sof_event,
  output logic             sof_token_req,
  output logic             fn_overflow_event,
  output logic             overrun_event,
  output logic [OVR_W-1:0] overrun_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_event         <= 1'b0;
      sof_token_req     <= 1'b0;
      fn_overflow_event <= 1'b0;
      overrun_event     <= 1'b0;
      overrun_count     <= '0;
    end else begin
      sof_event         <= fn_updated;
      sof_token_req     <= fn_updated;
      fn_overflow_event <= fn_updated && msb_toggled;
      overrun_event     <= fn_updated && busy_seen;
      if (fn_updated && busy_seen) overrun_count <= overrun_count + 1'b1;
    end
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int unsigned FIELD_W     = 16,
  parameter int unsigned FN_W        = 16,
  parameter int unsigned OVR_W       = 2,
  parameter int unsigned DEFAULT_IVL = 11999
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 sched_busy,
  input  logic                 cfg_we,
  input  logic [2*FIELD_W-1:0] cfg_wdata,
  output logic [FIELD_W-1:0]   remaining,
  output logic [FN_W-1:0]      frame_num,
  output logic                 fn_updated,
  output logic                 sof_event,
  output logic                 sof_token_req,
  output logic                 fn_overflow_event,
  output logic                 overrun_event,
  output logic [OVR_W-1:0]     overrun_count,
  output logic [FIELD_W-1:0]   interval_active,
  output logic [FIELD_W-1:0]   budget_active,
  output logic                 transaction_fits
);
  import ft_pkg::*;

  localparam int unsigned REG_W          = 2 * FIELD_W;
  localparam int unsigned DEFAULT_BUDGET = budget_of(DEFAULT_IVL);
  localparam logic [REG_W-1:0] DEFAULT_REG =
    {FIELD_W'(DEFAULT_BUDGET), FIELD_W'(DEFAULT_IVL)};

  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] act_q;
  logic             boundary;
  logic             msb_toggled;
  logic             busy_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= DEFAULT_REG;
    else if (cfg_we) pend_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= DEFAULT_REG;
    else if (boundary) act_q <= pend_q;
  end

  assign interval_active  = act_q[FIELD_W-1:0];
  assign budget_active    = act_q[REG_W-1:FIELD_W];
  assign transaction_fits = (remaining >= budget_active);

  ft_countdown #(.W(FIELD_W), .INIT_VAL(DEFAULT_IVL)) u_cd (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .reload_val (pend_q[FIELD_W-1:0]),
    .remaining  (remaining),
    .boundary   (boundary)
  );

  ft_frame_number #(.FN_W(FN_W)) u_fn (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary),
    .sched_busy  (sched_busy),
    .frame_num   (frame_num),
    .fn_updated  (fn_updated),
    .msb_toggled (msb_toggled),
    .busy_seen   (busy_seen)
  );

  ft_event_stage #(.OVR_W(OVR_W)) u_ev (
    .clk               (clk),
    .rst_n             (rst_n),
    .fn_updated        (fn_updated),
    .msb_toggled       (msb_toggled),
    .busy_seen         (busy_seen),
    .sof_event         (sof_event),
    .sof_token_req     (sof_token_req),
    .fn_overflow_event (fn_overflow_event),
    .overrun_event     (overrun_event),
    .overrun_count     (overrun_count)
  );
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned FN_W    = 16,
  parameter int unsigned OVR_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               tick,
  input logic [FIELD_W-1:0] remaining,
  input logic [FN_W-1:0]    frame_num,
  input logic               fn_updated,
  input logic               sof_event,
  input logic               sof_token_req,
  input logic               fn_overflow_event,
  input logic               overrun_event,
  input logic [OVR_W-1:0]   overrun_count,
  input logic [FIELD_W-1:0] interval_active
);
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && remaining != '0) |=> (remaining == $past(remaining) - 1'b1));

  p_fn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_updated |-> (frame_num == $past(frame_num) + 1'b1));

  p_sof_after_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fn_updated |=> (sof_event && sof_token_req));

  p_sof_needs_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_event |-> $past(fn_updated));

  p_overflow_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fn_overflow_event |-> ($past(frame_num[FN_W-1]) != $past(frame_num[FN_W-1], 2)));

  p_overrun_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_event |-> (overrun_count == $past(overrun_count) + 1'b1));

  p_interval_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(interval_active) |-> fn_updated);

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(frame_num) && $stable(remaining)));
endmodule

bind usb_frame_timer ft_checker #(
  .FIELD_W (FIELD_W),
  .FN_W    (FN_W),
  .OVR_W   (OVR_W)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .run               (run),
  .tick              (tick),
  .remaining         (remaining),
  .frame_num         (frame_num),
  .fn_updated        (fn_updated),
  .sof_event         (sof_event),
  .sof_token_req     (sof_token_req),
  .fn_overflow_event (fn_overflow_event),
  .overrun_event     (overrun_event),
  .overrun_count     (overrun_count),
  .interval_active   (interval_active)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, tick = 1'b0, sched_busy = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] remaining, frame_num, interval_active, budget_active;
  logic        fn_updated, sof_event, sof_token_req, fn_overflow_event, overrun_event;
  logic [1:0]  overrun_count;
  logic        transaction_fits;

  int n_checks = 0, n_fail = 0, cyc = 0, ovf_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .sched_busy(sched_busy),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .remaining(remaining),
    .frame_num(frame_num), .fn_updated(fn_updated), .sof_event(sof_event),
    .sof_token_req(sof_token_req), .fn_overflow_event(fn_overflow_event),
    .overrun_event(overrun_event), .overrun_count(overrun_count),
    .interval_active(interval_active), .budget_active(budget_active),
    .transaction_fits(transaction_fits)
  );

  // Behavioural reference: integer state plus a queue carrying frame records
  // from the update cycle to the start-of-frame cycle.
  typedef struct { bit flip; bit busy; } frame_rec_t;
  frame_rec_t evq[$];
  int m_rem, m_fn, m_pend_ivl, m_pend_bud, m_ivl, m_bud, m_cnt, m_ovf_total;
  bit m_upd, m_sof, m_ovf, m_ovr;

  task automatic model_reset();
    m_rem = 11999; m_fn = 0; m_pend_ivl = 11999;
    m_pend_bud = (6 * (11999 - 210)) / 7;
    m_ivl = m_pend_ivl; m_bud = m_pend_bud; m_cnt = 0;
    m_upd = 0; m_sof = 0; m_ovf = 0; m_ovr = 0; m_ovf_total = 0;
    evq.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      m_sof = 0; m_ovf = 0; m_ovr = 0;
      if (evq.size() > 0) begin
        frame_rec_t r;
        r = evq.pop_front();
        m_sof = 1; m_ovf = r.flip; m_ovr = r.busy;
        if (r.busy) m_cnt = (m_cnt + 1) % 4;
        if (r.flip) m_ovf_total++;
      end
      m_upd = 0;
      if (run && tick) begin
        if (m_rem == 0) begin
          frame_rec_t nr;
          nr.flip = ((m_fn / 32768) != (((m_fn + 1) % 65536) / 32768));
          nr.busy = sched_busy;
          evq.push_back(nr);
          m_fn = (m_fn + 1) % 65536;
          m_rem = m_pend_ivl; m_ivl = m_pend_ivl; m_bud = m_pend_bud;
          m_upd = 1;
        end else m_rem--;
      end
      if (cfg_we) begin
        m_pend_ivl = int'(cfg_wdata[15:0]);
        m_pend_bud = int'(cfg_wdata[31:16]);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2/R3 remaining", int'(remaining), m_rem);
      chk("R3 frame_num", int'(frame_num), m_fn);
      chk("R3 fn_updated", int'(fn_updated), int'(m_upd));
      chk("R4 sof_event", int'(sof_event), int'(m_sof));
      chk("R4 sof_token_req", int'(sof_token_req), int'(m_sof));
      chk("R5 fn_overflow_event", int'(fn_overflow_event), int'(m_ovf));
      chk("R6 overrun_event", int'(overrun_event), int'(m_ovr));
      chk("R6 overrun_count", int'(overrun_count), m_cnt);
      chk("R7 interval_active", int'(interval_active), m_ivl);
      chk("R7 budget_active", int'(budget_active), m_bud);
      chk("R8 transaction_fits", int'(transaction_fits), int'(m_rem >= m_bud));
      if (fn_overflow_event) ovf_seen++;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : stim
    int fn_hold, rem_hold, gap;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 frame_num", int'(frame_num), 0);
    chk("R1 remaining", int'(remaining), 11999);
    chk("R1 interval_active", int'(interval_active), 11999);
    chk("R1 budget_active", int'(budget_active), 10104);
    chk("R1 strobes", int'({fn_updated, sof_event, fn_overflow_event, overrun_event}), 0);
    chk("R1 overrun_count", int'(overrun_count), 0);

    // R2/R3/R4: one full default frame, ticks every cycle
    run = 1'b1; tick = 1'b1;
    gap = 0;
    while (!fn_updated && gap < 13000) begin @(negedge clk); gap++; end
    chk("R3 default frame length", gap, 12000);
    chk("R3 reload after boundary", int'(remaining), 11999);

    // R9: stopped timer holds
    run = 1'b0;
    step(3);
    fn_hold = int'(frame_num); rem_hold = int'(remaining);
    step(40);
    chk("R9 frame_num held", int'(frame_num), fn_hold);
    chk("R9 remaining held", int'(remaining), rem_hold);
    chk("R9 no sof while stopped", int'(sof_event), 0);

    // R7: write mid-frame, active config unchanged until boundary
    cfg_we = 1'b1; cfg_wdata = {16'd3, 16'd9};
    @(negedge clk); cfg_we = 1'b0;
    step(5);
    chk("R7 interval not yet applied", int'(interval_active), 11999);
    run = 1'b1;
    while (!fn_updated) @(negedge clk);
    chk("R7 interval applied at boundary", int'(interval_active), 9);
    chk("R7 budget applied at boundary", int'(budget_active), 3);

    // Random phase: gapped ticks, run toggles, busy schedules, writes
    for (int i = 0; i < 6000; i++) begin
      tick       = ($urandom % 4) != 0;
      run        = ($urandom % 20) != 0;
      sched_busy = ($urandom % 3) == 0;
      cfg_we     = ($urandom % 50) == 0;
      cfg_wdata  = {16'($urandom % 30), 16'(($urandom % 25) + 2)};
      @(negedge clk);
    end
    cfg_we = 1'b0; sched_busy = 1'b0;

    // R5: interval 0 makes every tick a boundary; cross bit 15 both ways
    run = 1'b1; tick = 1'b1;
    cfg_we = 1'b1; cfg_wdata = {16'd0, 16'd0};
    @(negedge clk); cfg_we = 1'b0;
    ovf_seen = 0;
    step(65600);
    run = 1'b0;
    step(4);
    chk("R5 both bit-15 toggles seen", int'(ovf_seen >= 2), 1);

    // R6: busy for five boundaries wraps the 2-bit counter
    fn_hold = int'(overrun_count);
    run = 1'b1; sched_busy = 1'b1;
    step(5);
    run = 1'b0; sched_busy = 1'b0;
    step(4);
    chk("R6 overrun count wraps mod 4", int'(overrun_count), (fn_hold + 5) % 4);
    step(2);
    finish_run();
  end
endmodule